// File: doc/BRIEF.md
# 10-bit Line Symbol Balance Monitor

This block watches a receive stream of 10-bit line symbols, one symbol per clock when a valid strobe is high. Each symbol carries six leading bits and four trailing bits. The block checks them against the DC-balance rules of the code. The six-bit part is judged first. The four-bit part is then judged against the disparity the six-bit part leaves behind. A running disparity is carried from one symbol to the next. Errors are raised for an illegal imbalance, for a sub-block that pushes the line further in the direction it already leans, and for a line that holds one level for too long.

The monitor also flags the two comma symbols. It publishes its running disparity together with a bit that says whether that value has been learned yet. Byte decoding, word alignment and clock recovery belong to other blocks. A typical use is a link-quality monitor placed beside the aligner: it counts error pulses and watches comma pulses.

Top module: `sym_balance_mon`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to 0 at that edge, and the running disparity returns to the unknown state.
- R2: Bits `sym[9:4]` form the six-bit sub-block and `sym[3:0]` form the four-bit sub-block. `sym[9]` is the first bit on the line and `sym[0]` is the last.
- R3: `disp_err` pulses when either sub-block has a ones-minus-zeros count outside {−2, 0, +2}, or when the whole symbol has a count outside that set.
- R4: After each sub-block the running disparity becomes positive on an excess of ones and negative on an excess of zeros. The balanced patterns 000111 and 0011 set it positive, 111000 and 1100 set it negative, and any other balanced pattern keeps it. `rd_pos` is 1 for positive.
- R5: `disp_err` pulses when a sub-block with nonzero disparity has the same sign as the running disparity it starts from, provided that disparity is known.
- R6: After reset `rd_valid` stays 0, and no same-sign error is raised, until a sub-block first assigns a sign under R4. From then on `rd_valid` stays 1 until the next reset.
- R7: `run_err` pulses when more than five identical bits arrive in a row. The count carries across symbol boundaries, and cycles with the strobe low neither extend nor break a run.
- R8: `comma_det` pulses for the symbols 0011111010 and 1100000101, written `sym[9]` first.
- R9: All flags appear one clock after the symbol that causes them and are 0 after a cycle with the strobe low. A cycle with the strobe low leaves `rd_pos` and `rd_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is present on `sym` this cycle |
| sym | input | 10 | Line symbol, bit 9 sent first |
| disp_err | output | 1 | Disparity or imbalance error for the previous symbol |
| run_err | output | 1 | Run of more than five equal bits seen |
| comma_det | output | 1 | Previous symbol was a comma |
| rd_pos | output | 1 | Running disparity, 1 = positive |
| rd_valid | output | 1 | Running disparity has been learned |

## Verification
The assertions check the cycle-level properties on every clock. Flags stay low after an idle cycle. The running disparity holds across idle cycles and, once learned, is never lost before reset. The comma flag only follows one of the two comma codes. The stored run length stays inside its range. The rules that need a symbol history can only be shown by the bench's scenarios, because they depend on what came before. These are the same-sign rule, the run carried across a boundary and an idle gap, the special balanced patterns, and the learning of the starting disparity after reset. For those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/sym_balance_pkg.sv
package sym_balance_pkg;
  typedef struct packed {
    logic known;
    logic pos;
  } rd_t;

  localparam logic [9:0] COMMA_NEG = 10'b0011111010;
  localparam logic [9:0] COMMA_POS = 10'b1100000101;
endpackage

// File: rtl/subblk_disp.sv
module subblk_disp
  import sym_balance_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [W-1:0] bits,
  input  rd_t          rd_in,
  output rd_t          rd_out,
  output logic         bad,
  output logic [$clog2(W+1)-1:0] ones
);
  localparam int CW = $clog2(W+1);
  localparam logic [CW-1:0] HALF    = CW'(W / 2);
  localparam logic [CW-1:0] HALF_P1 = CW'(W / 2 + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(W / 2 - 1);
  localparam logic [W-1:0]  POS_PAT = W'((1 << (W / 2)) - 1);
  localparam logic [W-1:0]  NEG_PAT = ~POS_PAT;

  logic heavy, light, too_heavy, too_light, same_sign;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CW'(bits[i]);
  end

  assign heavy     = ones > HALF;
  assign light     = ones < HALF;
  assign too_heavy = ones > HALF_P1;
  assign too_light = ones < HALF_M1;
  assign same_sign = rd_in.known && ((heavy && rd_in.pos) || (light && !rd_in.pos));
  assign bad       = too_heavy || too_light || same_sign;

  always_comb begin
    rd_out = rd_in;
    if (heavy || bits == POS_PAT) begin
      rd_out.known = 1'b1;
      rd_out.pos   = 1'b1;
    end else if (light || bits == NEG_PAT) begin
      rd_out.known = 1'b1;
      rd_out.pos   = 1'b0;
    end
  end
endmodule

// File: rtl/run_track.sv
module run_track #(
  parameter int SYM_W   = 10,
  parameter int MAX_RUN = 5,
  parameter int RW      = $clog2(MAX_RUN + 2)
) (
  input  logic [SYM_W-1:0] sym,
  input  logic             last_in,
  input  logic [RW-1:0]    run_in,
  output logic             last_out,
  output logic [RW-1:0]    run_out,
  output logic             over
);
  localparam logic [RW-1:0] SAT   = RW'(MAX_RUN + 1);
  localparam logic [RW-1:0] LIMIT = RW'(MAX_RUN);

  always_comb begin
    logic          l;
    logic [RW-1:0] r;
    l    = last_in;
    r    = run_in;
    over = 1'b0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      if (r != '0 && sym[i] == l) begin
        if (r < SAT) r = r + 1'b1;
      end else begin
        r = RW'(1);
      end
      l = sym[i];
      if (r > LIMIT) over = 1'b1;
    end
    last_out = l;
    run_out  = r;
  end
endmodule

// File: rtl/comma_match.sv
module comma_match
  import sym_balance_pkg::*;
#(
  parameter int SYM_W = 10
) (
  input  logic [SYM_W-1:0] sym,
  output logic             hit
);
  generate
    if (SYM_W == 10) begin : g_ten
      assign hit = (sym == COMMA_NEG) || (sym == COMMA_POS);
    end else begin : g_none
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sym_balance_mon.sv
module sym_balance_mon
  import sym_balance_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int HI_W    = 6,
  parameter int MAX_RUN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             disp_err,
  output logic             run_err,
  output logic             comma_det,
  output logic             rd_pos,
  output logic             rd_valid
);
  localparam int LO_W = SYM_W - HI_W;
  localparam int RW   = $clog2(MAX_RUN + 2);
  localparam int SCW  = $clog2(SYM_W + 1);
  localparam logic [SCW-1:0] SYM_HI = SCW'(SYM_W / 2 + 1);
  localparam logic [SCW-1:0] SYM_LO = SCW'(SYM_W / 2 - 1);

  rd_t rd_q, rd_mid, rd_next;
  logic last_q, last_next;
  logic [RW-1:0] run_q, run_next;
  logic bad_hi, bad_lo, bad_sym, run_over, is_comma;
  logic [$clog2(HI_W+1)-1:0] ones_hi;
  logic [$clog2(LO_W+1)-1:0] ones_lo;
  logic [SCW-1:0] ones_all;
  logic disp_err_q, run_err_q, comma_q;

  // R2: leading sub-block is judged first, trailing one uses its result
  subblk_disp #(.W(HI_W)) u_hi (
    .bits(sym[SYM_W-1:LO_W]), .rd_in(rd_q), .rd_out(rd_mid),
    .bad(bad_hi), .ones(ones_hi)
  );

  subblk_disp #(.W(LO_W)) u_lo (
    .bits(sym[LO_W-1:0]), .rd_in(rd_mid), .rd_out(rd_next),
    .bad(bad_lo), .ones(ones_lo)
  );

  assign ones_all = SCW'(ones_hi) + SCW'(ones_lo);
  assign bad_sym  = (ones_all > SYM_HI) || (ones_all < SYM_LO);

  run_track #(.SYM_W(SYM_W), .MAX_RUN(MAX_RUN), .RW(RW)) u_run (
    .sym(sym), .last_in(last_q), .run_in(run_q),
    .last_out(last_next), .run_out(run_next), .over(run_over)
  );

  comma_match #(.SYM_W(SYM_W)) u_comma (
    .sym(sym), .hit(is_comma)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      last_q     <= 1'b0;
      run_q      <= '0;
      disp_err_q <= 1'b0;
      run_err_q  <= 1'b0;
      comma_q    <= 1'b0;
    end else begin
      disp_err_q <= sym_valid && (bad_hi || bad_lo || bad_sym);
      run_err_q  <= sym_valid && run_over;
      comma_q    <= sym_valid && is_comma;
      if (sym_valid) begin
        rd_q   <= rd_next;
        last_q <= last_next;
        run_q  <= run_next;
      end
    end
  end

  assign disp_err  = disp_err_q;
  assign run_err   = run_err_q;
  assign comma_det = comma_q;
  assign rd_pos    = rd_q.pos;
  assign rd_valid  = rd_q.known;

  // R9
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> (!disp_err && !run_err && !comma_det));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> ($stable(rd_pos) && $stable(rd_valid)));

  // R6
  rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_valid);

  // R8
  comma_code_chk: assert property (@(posedge clk) disable iff (rst)
    comma_det |-> ($past(sym) == COMMA_NEG || $past(sym) == COMMA_POS));

  // R7
  run_range_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> (run_q != '0 && run_q <= RW'(MAX_RUN + 1)));
endmodule

// File: tb/sym_balance_mon_bench.sv
module sym_balance_mon_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [9:0] sym = '0;
  logic disp_err, run_err, comma_det, rd_pos, rd_valid;

  always #10 clk = ~clk;

  sym_balance_mon u_sym_balance_mon (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym),
    .disp_err(disp_err), .run_err(run_err), .comma_det(comma_det),
    .rd_pos(rd_pos), .rd_valid(rd_valid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit m_known = 0, m_pos = 0, m_last = 0;
  int m_run = 0;
  bit e_disp = 0, e_run = 0, e_comma = 0;
  bit phase_rst = 1, phase_idle = 0;

  task automatic chk(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, expv, $time);
    end
  endtask

  // one sub-block per R4/R5/R3; bit list is first-sent first
  function automatic bit judge(int w, int val);
    int ones = 0;
    int d;
    bit err = 0;
    for (int i = 0; i < w; i++) ones += (val >> i) & 1;
    d = 2 * ones - w;
    if (d > 2 || d < -2) err = 1;
    if (d != 0 && m_known && ((d > 0) == m_pos)) err = 1;
    if (d > 0) begin m_known = 1; m_pos = 1; end
    else if (d < 0) begin m_known = 1; m_pos = 0; end
    else if ((w == 6 && val == 7) || (w == 4 && val == 3)) begin m_known = 1; m_pos = 1; end
    else if ((w == 6 && val == 56) || (w == 4 && val == 12)) begin m_known = 1; m_pos = 0; end
    return err;
  endfunction

  task automatic model(bit v, logic [9:0] s);
    int ones = 0;
    bit e;
    e_disp = 0; e_run = 0; e_comma = 0;
    if (!v) return;
    // R2: upper six first, then lower four
    e = judge(6, int'(s[9:4]));
    e = judge(4, int'(s[3:0])) | e;
    for (int i = 0; i < 10; i++) ones += s[i];
    if (ones > 6 || ones < 4) e = 1;
    e_disp = e;
    for (int i = 9; i >= 0; i--) begin
      if (m_run != 0 && s[i] == m_last) m_run++;
      else m_run = 1;
      m_last = s[i];
      if (m_run > 5) e_run = 1;
    end
    e_comma = (s == 10'b0011111010) || (s == 10'b1100000101);
  endtask

  task automatic compare();
    string t_d, t_r, t_c, t_p, t_v;
    if (phase_rst) begin t_d = "R1"; t_r = "R1"; t_c = "R1"; t_p = "R1"; t_v = "R1"; end
    else if (phase_idle) begin t_d = "R9"; t_r = "R9"; t_c = "R9"; t_p = "R9"; t_v = "R9"; end
    else begin t_d = "R3 R5"; t_r = "R7"; t_c = "R8"; t_p = "R4"; t_v = "R6"; end
    chk(t_d, disp_err, e_disp, "disp_err");
    chk(t_r, run_err, e_run, "run_err");
    chk(t_c, comma_det, e_comma, "comma_det");
    chk(t_p, rd_pos, m_pos, "rd_pos");
    chk(t_v, rd_valid, m_known, "rd_valid");
  endtask

  task automatic step(bit r, bit v, logic [9:0] s);
    @(negedge clk);
    compare();
    rst = r; sym_valid = v; sym = s;
    if (r) begin
      m_known = 0; m_pos = 0; m_last = 0; m_run = 0;
      e_disp = 0; e_run = 0; e_comma = 0;
    end else begin
      model(v, s);
    end
    phase_rst = r;
    phase_idle = !r && !v;
  endtask

  task automatic send(logic [9:0] s); step(0, 1, s); endtask
  task automatic idle(); step(0, 0, '0); endtask

  initial begin
    step(1, 0, '0); step(1, 0, '0);
    // R8 and R4: commas alternate, starting disparity learned (R6)
    for (int i = 0; i < 4; i++) begin send(10'b0011111010); send(10'b1100000101); end
    // high transition pattern
    for (int i = 0; i < 4; i++) send(10'b1010101010);
    idle(); idle();
    // R5: same comma twice in a row repeats the same sign
    send(10'b0011111010); send(10'b0011111010);
    // R3: six ones in leading sub-block, also R7 run of six
    send(10'b1111110000);
    // R7: run spans a boundary and an idle gap
    step(1, 0, '0);
    send(10'b1010100000); idle(); send(10'b0111010100);
    // R4: special balanced patterns set sign
    step(1, 0, '0);
    send(10'b0001110011); send(10'b1110001100); send(10'b1001011010);
    // R6: balanced non-special symbol leaves disparity unknown
    step(1, 0, '0);
    send(10'b1010101010); send(10'b0110100101); send(10'b0111100100);
    // mixed traffic
    for (int i = 0; i < 400; i++) step(0, ($urandom % 4) != 0, 10'($urandom));
    step(1, 0, '0);
    for (int i = 0; i < 200; i++) begin
      int pick = $urandom % 4;
      logic [9:0] s;
      case (pick)
        0: s = 10'b0011111010;
        1: s = 10'b1100000101;
        2: s = 10'b0111100100;
        default: s = 10'b1000011011;
      endcase
      step(0, ($urandom % 5) != 0, s);
    end
    step(0, 0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule